// File: doc/BRIEF.md
# Fractional-N Divide Value Sequencer

This block sits next to the feedback counter of a fractional-N synthesizer. For every phase-detector comparison cycle it hands the counter an integer divide value. Over many cycles the average of those values is INT + FRAC/MOD. The fractional part comes from a three-stage cascade of first-order accumulators. Each accumulator wraps at a modulus that software can set to any value, not only a power of two. A pseudo-random single-LSB injection can be switched on to break up idle tones, or left off for the cleanest spur profile.

The block also generates the comparison tick itself, as a clock-enable path. Strobes marking the reference edges pass through a selectable doubler or halver and then a 4-bit reference counter. Each resulting tick steps the modulator once.

Software stages INT, FRAC, MOD and the dither switch with one load strobe. The staged set goes live only on the next comparison tick, and at that moment the accumulators restart from zero.

Top module: `fracn_divctl`

## Requirements
- R1: While reset is held and immediately after it is released, `pfd_tick`, `div_valid` and `div_value` are all zero.
- R2: With dither off, after n divide values following the application of a setting, the sum of (`div_value` − INT) over those n values differs from floor(n·FRAC/MOD) by no less than −1 and no more than +2. Every accumulator stays below the active modulus.
- R3: Every issued `div_value` lies between INT − 3 and INT + 4 inclusive.
- R4: With FRAC = 0 and dither off, every issued `div_value` equals INT.
- R5: `div_valid` is high for exactly the one clock that follows each `pfd_tick` pulse and is low at all other times. `div_value` holds its value whenever `div_valid` is low.
- R6: A setting loaded with `cfg_load` affects nothing until the next `pfd_tick`. Values issued before that tick still use the old setting. On that tick the accumulators and the carry history are cleared, so reapplying the same setting with dither off reproduces the same sequence.
- R7: With `cfg_dither` = 1 and FRAC = 0, the issued values leave INT at least once within 64 ticks. The dither source is a 23-bit LFSR with taps 23 and 18 that advances once per tick, and only its bit 0 is injected into the first accumulator.
- R8: Each qualifying reference event is one clock wide, and `pfd_tick` pulses one clock after every `ref_div`-th such event (`ref_div` = 0 acts as 1). The events selected by `ref_mode` are: 2'b00 = every `ref_rise`; 2'b01 = every `ref_rise` and every `ref_fall`; 2'b10 = every second `ref_rise`; 2'b11 = as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_rise | input | 1 | One-clock strobe marking a reference rising edge |
| ref_fall | input | 1 | One-clock strobe marking a reference falling edge |
| ref_mode | input | 2 | Edge selection: direct, doubled, halved |
| ref_div | input | R_W | Reference counter divide ratio (0 acts as 1) |
| cfg_load | input | 1 | Stages the four setting fields below |
| cfg_int | input | INT_W | Integer part of the ratio |
| cfg_frac | input | MOD_W | Fractional numerator, must be below cfg_mod |
| cfg_mod | input | MOD_W | Modulus, at least 1 |
| cfg_dither | input | 1 | Enables the pseudo-random LSB injection |
| pfd_tick | output | 1 | Comparison-cycle tick |
| div_value | output | INT_W | Divide value for the feedback counter |
| div_valid | output | 1 | High for the clock in which div_value is new |

## Verification
The bench uses the default widths: a 12-bit integer field, a 12-bit modulus and a 4-bit reference counter. These widths admit moduli of 130 and 65 next to very small ones such as 13 and 2, and divide ratios from 1 to 15. The running-sum bound is tracked tick by tick for several FRAC/MOD pairs, long enough to cover two full modulus periods of 130. The doubled, halved and divide-by-zero reference settings are exercised, as is a setting staged between ticks.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;
    // Reference edge selection ahead of the reference counter
    typedef enum logic [1:0] {
        REF_DIRECT = 2'b00,
        REF_DOUBLE = 2'b01,
        REF_HALVE  = 2'b10,
        REF_SPARE  = 2'b11
    } ref_mode_e;

    // Number of cascaded accumulators (cancellation network assumes three)
    localparam int NSTG = 3;
endpackage

// File: rtl/fracn_refpath.sv
`timescale 1ns/1ps
module fracn_refpath #(
    parameter int R_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_rise,
    input  logic           ref_fall,
    input  logic [1:0]     mode,
    input  logic [R_W-1:0] rdiv,
    output logic           tick_o
);
    import fracn_pkg::*;

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic           half;
        logic           tick;
    } rp_t;

    rp_t st_d, st_q;
    logic           ev;
    logic [R_W:0]   lim;
    logic [R_W:0]   nxt;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (ref_rise) st_d.half = ~st_q.half;
        unique case (ref_mode_e'(mode))
            REF_DOUBLE: ev = ref_rise | ref_fall;
            REF_HALVE:  ev = ref_rise & st_q.half;
            default:    ev = ref_rise;
        endcase
        lim = (rdiv == '0) ? (R_W+1)'(1) : {1'b0, rdiv};
        nxt = {1'b0, st_q.cnt} + (R_W+1)'(1);
        if (ev) begin
            if (nxt >= lim) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = nxt[R_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/fracn_lfsr.sv
`timescale 1ns/1ps
module fracn_lfsr #(
    parameter int           W    = 23,
    parameter int           TAP  = 18,
    parameter logic [W-1:0] SEED = W'(24'h1ACE5)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic bit_o
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (step) q_d = {q_q[W-2:0], q_q[W-1] ^ q_q[TAP-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= SEED;
        else        q_q <= q_d;
    end

    assign bit_o = q_q[0];
endmodule

// File: rtl/fracn_acc_stage.sv
`timescale 1ns/1ps
module fracn_acc_stage #(
    parameter int MOD_W = 12
) (
    input  logic [MOD_W-1:0] acc_i,
    input  logic [MOD_W:0]   inc_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic [MOD_W-1:0] acc_o,
    output logic             carry_o
);
    logic [MOD_W:0] sum;
    logic [MOD_W:0] red;

    // Both operands are below the modulus, so one subtraction is enough
    assign sum     = {1'b0, acc_i} + inc_i;
    assign carry_o = (sum >= {1'b0, mod_i});
    assign red     = sum - {1'b0, mod_i};
    assign acc_o   = carry_o ? red[MOD_W-1:0] : sum[MOD_W-1:0];
endmodule

// File: rtl/fracn_divctl.sv
`timescale 1ns/1ps
module fracn_divctl #(
    parameter int INT_W = 12,
    parameter int MOD_W = 12,
    parameter int R_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             ref_fall,
    input  logic [1:0]       ref_mode,
    input  logic [R_W-1:0]   ref_div,
    input  logic             cfg_load,
    input  logic [INT_W-1:0] cfg_int,
    input  logic [MOD_W-1:0] cfg_frac,
    input  logic [MOD_W-1:0] cfg_mod,
    input  logic             cfg_dither,
    output logic             pfd_tick,
    output logic [INT_W-1:0] div_value,
    output logic             div_valid
);
    import fracn_pkg::*;

    localparam int Y_W = 4;

    typedef struct packed {
        logic [INT_W-1:0] int_v;
        logic [MOD_W-1:0] frac_v;
        logic [MOD_W-1:0] mod_v;
        logic             dith;
    } cfg_t;

    typedef struct packed {
        cfg_t                             act;
        cfg_t                             pend;
        logic                             pend_ok;
        logic [NSTG-1:0][MOD_W-1:0]       acc;
        logic                             c2_p;
        logic                             c3_p;
        logic                             c3_pp;
        logic [INT_W-1:0]                 div;
        logic                             vld;
    } st_t;

    st_t  st_d, st_q;
    cfg_t cur;
    logic apply;
    logic dith_bit;
    logic [Y_W-1:0] y;
    logic h2, h3, h3p;

    logic [MOD_W-1:0] acc_base [NSTG];
    logic [MOD_W:0]   stg_inc  [NSTG];
    logic [MOD_W-1:0] acc_nx   [NSTG];
    logic [NSTG-1:0]  cy;

    fracn_refpath #(.R_W(R_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
        .mode(ref_mode), .rdiv(ref_div), .tick_o(pfd_tick)
    );

    fracn_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .step(pfd_tick), .bit_o(dith_bit));

    assign apply = pfd_tick & st_q.pend_ok;
    assign cur   = apply ? st_q.pend : st_q.act;

    for (genvar g = 0; g < NSTG; g++) begin : g_stg
        assign acc_base[g] = apply ? '0 : st_q.acc[g];
        if (g == 0) begin : g_head
            assign stg_inc[g] = {1'b0, cur.frac_v} + (MOD_W+1)'(cur.dith & dith_bit);
        end else begin : g_tail
            assign stg_inc[g] = {1'b0, acc_nx[g-1]};
        end
        fracn_acc_stage #(.MOD_W(MOD_W)) u_stage (
            .acc_i(acc_base[g]), .inc_i(stg_inc[g]), .mod_i(cur.mod_v),
            .acc_o(acc_nx[g]), .carry_o(cy[g])
        );
    end

    assign h2  = apply ? 1'b0 : st_q.c2_p;
    assign h3  = apply ? 1'b0 : st_q.c3_p;
    assign h3p = apply ? 1'b0 : st_q.c3_pp;

    // Noise-cancelling combination: c1 + d(c2) + d2(c3), range -3..+4
    assign y = Y_W'(cy[0]) + Y_W'(cy[1]) - Y_W'(h2) + Y_W'(cy[2])
             - {2'b00, h3, 1'b0} + Y_W'(h3p);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (pfd_tick) begin
            if (apply) begin
                st_d.act     = st_q.pend;
                st_d.pend_ok = 1'b0;
            end
            for (int i = 0; i < NSTG; i++) st_d.acc[i] = acc_nx[i];
            st_d.c2_p  = cy[1];
            st_d.c3_p  = cy[2];
            st_d.c3_pp = h3;
            st_d.div   = cur.int_v + {{(INT_W-Y_W){y[Y_W-1]}}, y};
            st_d.vld   = 1'b1;
        end
        if (cfg_load) begin
            st_d.pend    = '{int_v: cfg_int, frac_v: cfg_frac, mod_v: cfg_mod, dith: cfg_dither};
            st_d.pend_ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.act.mod_v <= MOD_W'(1);
            st_q.pend.mod_v <= MOD_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign div_value = st_q.div;
    assign div_valid = st_q.vld;
endmodule

// File: rtl/fracn_divctl_chk.sv
`timescale 1ns/1ps
module fracn_divctl_chk #(
    parameter int INT_W = 12,
    parameter int MOD_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pfd_tick,
    input logic                   div_valid,
    input logic [INT_W-1:0]       div_value,
    input logic [INT_W-1:0]       int_act,
    input logic [MOD_W-1:0]       frac_act,
    input logic [MOD_W-1:0]       mod_act,
    input logic                   dith_act,
    input logic [2:0][MOD_W-1:0]  acc
);
    logic [INT_W-1:0] dlt;
    logic             in_rng;

    assign dlt    = div_value - int_act;
    assign in_rng = (dlt <= INT_W'(4)) || (dlt >= ({INT_W{1'b1}} - INT_W'(2)));

    p_tick_gives_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pfd_tick |=> div_valid);

    p_value_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |-> $past(pfd_tick));

    p_value_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !div_valid |-> $stable(div_value));

    p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |-> in_rng);

    p_acc_below_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[0] < mod_act) && (acc[1] < mod_act) && (acc[2] < mod_act));

    p_integer_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && frac_act == '0 && !dith_act) |-> (div_value == int_act));
endmodule

bind fracn_divctl fracn_divctl_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .div_valid(div_valid),
    .div_value(div_value), .int_act(st_q.act.int_v), .frac_act(st_q.act.frac_v),
    .mod_act(st_q.act.mod_v), .dith_act(st_q.act.dith), .acc(st_q.acc)
);

// File: tb/fracn_divctl_test.sv
`timescale 1ns/1ps
module fracn_divctl_test;
    localparam int INT_W = 12;
    localparam int MOD_W = 12;
    localparam int R_W   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_rise = 1'b0, ref_fall = 1'b0;
    logic [1:0]       ref_mode = 2'b00;
    logic [R_W-1:0]   ref_div = 4'd1;
    logic             cfg_load = 1'b0;
    logic [INT_W-1:0] cfg_int = '0;
    logic [MOD_W-1:0] cfg_frac = '0;
    logic [MOD_W-1:0] cfg_mod = 12'd1;
    logic             cfg_dither = 1'b0;
    logic             pfd_tick;
    logic [INT_W-1:0] div_value;
    logic             div_valid;

    int n_chk = 0, n_bad = 0;
    int pfd_cnt = 0;

    fracn_divctl uut (.*);

    always #2 clk = ~clk;

    always @(negedge clk) if (pfd_tick) pfd_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input int iv, input int fv, input int mv, input bit dt);
        @(negedge clk);
        cfg_int = INT_W'(iv); cfg_frac = MOD_W'(fv); cfg_mod = MOD_W'(mv);
        cfg_dither = dt; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // One reference rising edge in direct mode; returns tick/valid/value
    task automatic step(output bit got_pfd, output bit got_vld, output int v);
        @(negedge clk) ref_rise = 1'b1;
        @(negedge clk) ref_rise = 1'b0;
        got_pfd = pfd_tick;
        @(negedge clk);
        got_vld = div_valid;
        v = int'(div_value);
        @(negedge clk);
    endtask

    task automatic edge_ev(input bit r, input bit f);
        @(negedge clk) begin ref_rise = r; ref_fall = f; end
        @(negedge clk) begin ref_rise = 1'b0; ref_fall = 1'b0; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(pfd_tick == 1'b0 && div_valid == 1'b0, "R1", "tick/valid after reset",
              {pfd_tick, div_valid}, 0);
        check(div_value == '0, "R1", "div_value after reset", div_value, 0);
    endtask

    task automatic t_integer_only();
        bit p, vl; int v; bit all_ok = 1'b1, all_vld = 1'b1;
        load(100, 0, 13, 1'b0);
        for (int k = 0; k < 20; k++) begin
            step(p, vl, v);
            if (v != 100) all_ok = 1'b0;
            if (!(p && vl)) all_vld = 1'b0;
        end
        check(all_ok, "R4", "FRAC=0 value", v, 100);
        check(all_vld, "R5", "valid one clock after each tick", all_vld, 1);
        @(negedge clk);
        check(div_valid == 1'b0, "R5", "no valid without tick", div_valid, 0);
    endtask

    task automatic t_boundary();
        bit p, vl; int v;
        load(200, 0, 13, 1'b0);
        repeat (3) @(negedge clk);
        check(div_value == 12'd100, "R6", "old value before tick", div_value, 100);
        check(div_valid == 1'b0, "R5", "valid stays low between ticks", div_valid, 0);
        step(p, vl, v);
        check(v == 200, "R6", "new INT after tick", v, 200);
    endtask

    task automatic run_sum(input int iv, input int fv, input int mv, input int n);
        bit p, vl; int v; longint s = 0; longint err;
        load(iv, fv, mv, 1'b0);
        for (int k = 1; k <= n; k++) begin
            step(p, vl, v);
            check((v >= iv - 3) && (v <= iv + 4), "R3", "value within INT-3..INT+4", v, iv);
            s += longint'(v - iv);
            err = s - (longint'(k) * fv) / mv;
            check((err >= -1) && (err <= 2), "R2", "running sum minus floor(n*FRAC/MOD)", err, 0);
        end
    endtask

    task automatic t_repeat();
        bit p, vl; int v; int a [30]; bit same = 1'b1;
        load(42, 4, 130, 1'b0);
        for (int k = 0; k < 30; k++) begin step(p, vl, v); a[k] = v; end
        load(42, 4, 130, 1'b0);
        for (int k = 0; k < 30; k++) begin
            step(p, vl, v);
            if (v != a[k]) same = 1'b0;
        end
        check(same, "R6", "sequence restarts from cleared state", same, 1);
    endtask

    task automatic t_dither();
        bit p, vl; int v; bit moved = 1'b0, rng = 1'b1;
        load(100, 0, 13, 1'b1);
        for (int k = 0; k < 64; k++) begin
            step(p, vl, v);
            if (v != 100) moved = 1'b1;
            if (v < 97 || v > 104) rng = 1'b0;
        end
        check(moved, "R7", "dither moves value off INT", moved, 1);
        check(rng, "R3", "dithered value within range", rng, 1);
    endtask

    task automatic t_ref_modes();
        int c0;
        load(50, 0, 13, 1'b0);
        ref_mode = 2'b00; ref_div = 4'd3; c0 = pfd_cnt;
        repeat (6) edge_ev(1'b1, 1'b0);
        check(pfd_cnt - c0 == 2, "R8", "direct, divide by 3", pfd_cnt - c0, 2);
        ref_mode = 2'b01; ref_div = 4'd1; c0 = pfd_cnt;
        repeat (3) begin edge_ev(1'b1, 1'b0); edge_ev(1'b0, 1'b1); end
        check(pfd_cnt - c0 == 6, "R8", "doubled edges", pfd_cnt - c0, 6);
        ref_mode = 2'b10; c0 = pfd_cnt;
        repeat (4) edge_ev(1'b1, 1'b0);
        check(pfd_cnt - c0 == 2, "R8", "halved edges", pfd_cnt - c0, 2);
        ref_mode = 2'b00; ref_div = 4'd0; c0 = pfd_cnt;
        repeat (3) edge_ev(1'b1, 1'b0);
        check(pfd_cnt - c0 == 3, "R8", "divide value 0 acts as 1", pfd_cnt - c0, 3);
        ref_mode = 2'b11; ref_div = 4'd1; c0 = pfd_cnt;
        repeat (2) begin edge_ev(1'b1, 1'b0); edge_ev(1'b0, 1'b1); end
        check(pfd_cnt - c0 == 2, "R8", "spare code as direct", pfd_cnt - c0, 2);
        ref_mode = 2'b00;
    endtask

    initial begin
        #600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integer_only();
        t_boundary();
        run_sum(42, 4, 130, 260);
        run_sum(50, 7, 65, 130);
        run_sum(20, 12, 13, 52);
        run_sum(30, 1, 2, 8);
        t_repeat();
        t_dither();
        t_ref_modes();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule